// File: doc/BRIEF.md
# Mixed-Criticality Ready-Task Scheduler

This block keeps a small table of task slots and, every cycle, names the one ready task that should run on the processor next. Each slot holds a criticality class, a period, an absolute deadline, a next-release time, an arrival stamp and two flags: loaded and ready. Classes are strictly ranked: hard real-time above soft real-time above plain tasks. Inside each class a separate policy applies. Hard tasks run earliest deadline first. Soft tasks run shortest period first. Plain tasks run in arrival order. There is no blocked or sleeping state. A slot is either ready or not released, and a timed wait is a periodic slot whose next release is still ahead.

Software drives the table through a one-command-per-cycle write stream (`wr_valid`/`wr_ready`). `wr_ready` is high at all times after reset, so the stream never back-pressures and every cycle with `wr_valid` high is one accepted command. A command takes effect at the clock edge that accepts it, and the pick outputs show the new choice in the following cycle. A free-running tick counter is shown on `rt_now`. Periodic slots release themselves when the counter reaches their next-release time. The pick outputs and the `preempt` pulse are plain status pins with no handshake.

Top module: `mc_task_sched`

## Requirements
- R1: After reset, `pick_valid` and `preempt` are 0, no slot is loaded or ready, `wr_ready` is 1 and `rt_now` starts from 0.
- R2: If any ready slot has class code 2 (hard), the picked slot is a hard slot.
- R3: If no hard slot is ready and a slot of class code 1 (soft) is ready, the picked slot is soft; class code 0 (and 3, stored as 0) is plain.
- R4: Among ready hard slots, the one with the earliest absolute deadline is picked. Deadlines are compared by wrap-safe 16-bit subtraction, so 0xFFF0 is earlier than 0x0010.
- R5: Among ready soft slots, the one with the smallest period is picked.
- R6: Among ready plain slots, the one that became ready first is picked, regardless of slot index.
- R7: Equal keys within a class go to the lowest slot index.
- R8: Command op 2 (done) clears the slot's ready flag, and op 3 (remove) unloads the slot. `pick_valid` is 0 exactly when no slot is ready.
- R9: Op 0 (load) stores class, period, periodic flag and next-release time (`wr_time`) and leaves the slot not ready. Op 1 (release) makes a loaded slot ready with deadline `wr_time`. A release aimed at an unloaded slot has no effect.
- R10: `preempt` is high for a cycle exactly when `pick_valid` is high in this cycle and the previous one and `pick_idx` differs from its previous value.
- R11: `wr_ready` stays 1, and one command is accepted in every cycle with `wr_valid` high, including back-to-back cycles.
- R12: A loaded periodic slot becomes ready at the edge where the tick counter equals its next-release time. Its deadline becomes that time plus its period, and its next-release time advances by its period.
- R13: With the default divider of 1, `rt_now` increases by exactly 1 each cycle and wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Command present on the write stream |
| wr_ready | output | 1 | Write stream can accept (always 1 after reset) |
| wr_op | input | 2 | 0 load, 1 release, 2 done, 3 remove |
| wr_slot | input | 3 | Target slot index |
| wr_cls | input | 2 | Class for load: 0 plain, 1 soft, 2 hard |
| wr_periodic | input | 1 | Load: slot releases itself from the tick counter |
| wr_period | input | 16 | Load: period in ticks |
| wr_time | input | 16 | Load: first release time; release: absolute deadline |
| pick_valid | output | 1 | Some slot is ready |
| pick_idx | output | 3 | Index of the chosen slot |
| preempt | output | 1 | One-cycle pulse when the choice moves to another slot |
| rt_now | output | 16 | Current tick count |

## Verification
The assertions assume that the ready hard deadlines and the plain arrival stamps lie within half the 16-bit range of each other, so that wrap-safe ordering is total. They also assume that class code 3 is not relied on. The bench keeps every pair of live deadlines within a few dozen ticks of each other, except for a deliberate straddle of the wrap point. It only issues arrival-order tests with a few arrivals. It sets periodic release times a few ticks ahead of the counter, so each self-release lands at a cycle the bench can predict exactly.

// File: rtl/mc_sched_pkg.sv
package mc_sched_pkg;

  localparam int TS_W = 16;

  typedef enum logic [1:0] {
    CLS_NRT = 2'd0,
    CLS_SRT = 2'd1,
    CLS_HRT = 2'd2
  } crit_e;

  typedef enum logic [1:0] {
    OP_LOAD    = 2'd0,
    OP_RELEASE = 2'd1,
    OP_DONE    = 2'd2,
    OP_REMOVE  = 2'd3
  } wr_op_e;

  typedef struct packed {
    logic            loaded;
    logic            ready;
    logic            periodic;
    crit_e           cls;
    logic [TS_W-1:0] period;
    logic [TS_W-1:0] deadline;
    logic [TS_W-1:0] next_rel;
    logic [TS_W-1:0] stamp;
  } slot_t;

  // a strictly precedes b on a wrapping time line
  function automatic logic ts_before(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    logic signed [TS_W-1:0] diff;
    diff = a - b;
    return diff < 0;
  endfunction

  // candidate a outranks b: class first, then the class-specific key
  function automatic logic outranks(input crit_e ca, input logic [TS_W-1:0] ka,
                                    input crit_e cb, input logic [TS_W-1:0] kb);
    if (ca != cb) return ca > cb;
    case (ca)
      CLS_HRT: return ts_before(ka, kb);
      CLS_SRT: return ka < kb;
      default: return ts_before(ka, kb);
    endcase
  endfunction

  function automatic crit_e decode_cls(input logic [1:0] code);
    case (code)
      2'd1:    return CLS_SRT;
      2'd2:    return CLS_HRT;
      default: return CLS_NRT;
    endcase
  endfunction

endpackage

// File: rtl/mc_tick_gen.sv
module mc_tick_gen #(
  parameter int TS_W     = 16,
  parameter int TICK_DIV = 1
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] now_o
);

  logic [TS_W-1:0] now_q;
  assign now_o = now_q;

  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      always_ff @(posedge clk) begin
        if (rst) now_q <= '0;
        else     now_q <= now_q + 1'b1;
      end
    end else begin : g_divided
      localparam int DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre_q <= '0;
          now_q <= '0;
        end else if (pre_q == DIV_LAST) begin
          pre_q <= '0;
          now_q <= now_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/mc_slot_table.sv
module mc_slot_table
  import mc_sched_pkg::*;
#(
  parameter int N_TASKS = 8,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  now_i,
  input  logic             wr_fire,
  input  wr_op_e           wr_op,
  input  logic [IDX_W-1:0] wr_slot,
  input  crit_e            wr_cls,
  input  logic             wr_periodic,
  input  logic [TS_W-1:0]  wr_period,
  input  logic [TS_W-1:0]  wr_time,
  output logic [N_TASKS-1:0] rdy_o,
  output crit_e            cls_o   [N_TASKS],
  output logic [TS_W-1:0]  dl_o    [N_TASKS],
  output logic [TS_W-1:0]  per_o   [N_TASKS],
  output logic [TS_W-1:0]  stamp_o [N_TASKS]
);

  slot_t ent_q [N_TASKS];
  slot_t ent_d [N_TASKS];
  logic [TS_W-1:0]    stamp_q, stamp_d;
  logic [N_TASKS-1:0] due;
  logic [N_TASKS-1:0] arrive;

  // timer-driven release of periodic slots
  always_comb begin
    for (int i = 0; i < N_TASKS; i++) begin
      due[i] = ent_q[i].loaded && ent_q[i].periodic && !ts_before(now_i, ent_q[i].next_rel);
    end
  end

  always_comb begin
    ent_d  = ent_q;
    arrive = '0;
    for (int i = 0; i < N_TASKS; i++) begin
      if (due[i]) begin
        ent_d[i].ready    = 1'b1;
        ent_d[i].deadline = ent_q[i].next_rel + ent_q[i].period;
        ent_d[i].next_rel = ent_q[i].next_rel + ent_q[i].period;
        arrive[i]         = !ent_q[i].ready;
      end
      // a command to the same slot wins over a timer release
      if (wr_fire && (wr_slot == IDX_W'(i))) begin
        case (wr_op)
          OP_LOAD: begin
            ent_d[i].loaded   = 1'b1;
            ent_d[i].ready    = 1'b0;
            ent_d[i].periodic = wr_periodic;
            ent_d[i].cls      = wr_cls;
            ent_d[i].period   = wr_period;
            ent_d[i].deadline = '0;
            ent_d[i].next_rel = wr_time;
            ent_d[i].stamp    = '0;
            arrive[i]         = 1'b0;
          end
          OP_RELEASE: begin
            if (ent_q[i].loaded) begin
              ent_d[i].ready    = 1'b1;
              ent_d[i].deadline = wr_time;
              arrive[i]         = !ent_q[i].ready;
            end
          end
          OP_DONE: begin
            ent_d[i].ready = 1'b0;
            arrive[i]      = 1'b0;
          end
          default: begin
            ent_d[i]  = '0;
            arrive[i] = 1'b0;
          end
        endcase
      end
      if (arrive[i]) ent_d[i].stamp = stamp_q;
    end
    stamp_d = stamp_q + TS_W'(|arrive);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_TASKS; i++) ent_q[i] <= '0;
      stamp_q <= '0;
    end else begin
      ent_q   <= ent_d;
      stamp_q <= stamp_d;
    end
  end

  generate
    for (genvar g = 0; g < N_TASKS; g++) begin : g_out
      assign rdy_o[g]   = ent_q[g].loaded && ent_q[g].ready;
      assign cls_o[g]   = ent_q[g].cls;
      assign dl_o[g]    = ent_q[g].deadline;
      assign per_o[g]   = ent_q[g].period;
      assign stamp_o[g] = ent_q[g].stamp;
    end
  endgenerate

endmodule

// File: rtl/mc_pick_unit.sv
module mc_pick_unit
  import mc_sched_pkg::*;
#(
  parameter int N_TASKS = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_TASKS-1:0] rdy_i,
  input  crit_e              cls_i   [N_TASKS],
  input  logic [TS_W-1:0]    dl_i    [N_TASKS],
  input  logic [TS_W-1:0]    per_i   [N_TASKS],
  input  logic [TS_W-1:0]    stamp_i [N_TASKS],
  output logic               pick_valid_o,
  output logic [IDX_W-1:0]   pick_idx_o
);

  logic [TS_W-1:0] key [N_TASKS];

  // per-slot ordering key chosen by the slot's class
  generate
    for (genvar g = 0; g < N_TASKS; g++) begin : g_key
      assign key[g] = (cls_i[g] == CLS_HRT) ? dl_i[g] :
                      (cls_i[g] == CLS_SRT) ? per_i[g] : stamp_i[g];
    end
  endgenerate

  logic            best_v;
  logic [IDX_W-1:0] best_i;
  crit_e           best_c;
  logic [TS_W-1:0] best_k;

  // ascending scan; only a strictly better slot replaces, so ties keep the lower index
  always_comb begin
    best_v = 1'b0;
    best_i = '0;
    best_c = CLS_NRT;
    best_k = '0;
    for (int i = 0; i < N_TASKS; i++) begin
      if (rdy_i[i] && (!best_v || outranks(cls_i[i], key[i], best_c, best_k))) begin
        best_v = 1'b1;
        best_i = IDX_W'(i);
        best_c = cls_i[i];
        best_k = key[i];
      end
    end
  end

  assign pick_valid_o = best_v;
  assign pick_idx_o   = best_i;

endmodule

// File: rtl/mc_task_sched.sv
module mc_task_sched
  import mc_sched_pkg::*;
#(
  parameter int N_TASKS  = 8,
  parameter int TICK_DIV = 1,
  localparam int IDX_W   = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [1:0]       wr_op,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [1:0]       wr_cls,
  input  logic             wr_periodic,
  input  logic [15:0]      wr_period,
  input  logic [15:0]      wr_time,
  output logic             pick_valid,
  output logic [IDX_W-1:0] pick_idx,
  output logic             preempt,
  output logic [15:0]      rt_now
);

  logic [TS_W-1:0]    now;
  logic [N_TASKS-1:0] rdy_vec;
  crit_e              cls_arr   [N_TASKS];
  logic [TS_W-1:0]    dl_arr    [N_TASKS];
  logic [TS_W-1:0]    per_arr   [N_TASKS];
  logic [TS_W-1:0]    stamp_arr [N_TASKS];
  logic [N_TASKS-1:0] hrt_vec;
  logic [N_TASKS-1:0] srt_vec;
  logic               prev_v_q;
  logic [IDX_W-1:0]   prev_i_q;

  assign wr_ready = 1'b1;

  mc_tick_gen #(
    .TS_W     (TS_W),
    .TICK_DIV (TICK_DIV)
  ) u_tick (
    .clk   (clk),
    .rst   (rst),
    .now_o (now)
  );

  mc_slot_table #(
    .N_TASKS (N_TASKS),
    .IDX_W   (IDX_W)
  ) u_table (
    .clk         (clk),
    .rst         (rst),
    .now_i       (now),
    .wr_fire     (wr_valid && wr_ready),
    .wr_op       (wr_op_e'(wr_op)),
    .wr_slot     (wr_slot),
    .wr_cls      (decode_cls(wr_cls)),
    .wr_periodic (wr_periodic),
    .wr_period   (wr_period),
    .wr_time     (wr_time),
    .rdy_o       (rdy_vec),
    .cls_o       (cls_arr),
    .dl_o        (dl_arr),
    .per_o       (per_arr),
    .stamp_o     (stamp_arr)
  );

  mc_pick_unit #(
    .N_TASKS (N_TASKS),
    .IDX_W   (IDX_W)
  ) u_pick (
    .rdy_i        (rdy_vec),
    .cls_i        (cls_arr),
    .dl_i         (dl_arr),
    .per_i        (per_arr),
    .stamp_i      (stamp_arr),
    .pick_valid_o (pick_valid),
    .pick_idx_o   (pick_idx)
  );

  // class masks, consumed by the bound checker
  always_comb begin
    for (int i = 0; i < N_TASKS; i++) begin
      hrt_vec[i] = (cls_arr[i] == CLS_HRT);
      srt_vec[i] = (cls_arr[i] == CLS_SRT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_v_q <= 1'b0;
      prev_i_q <= '0;
    end else begin
      prev_v_q <= pick_valid;
      prev_i_q <= pick_idx;
    end
  end

  assign preempt = pick_valid && prev_v_q && (pick_idx != prev_i_q);
  assign rt_now  = now;

endmodule

// File: rtl/mc_task_sched_chk.sv
module mc_task_sched_chk #(
  parameter int N_TASKS = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               pick_valid,
  input logic [IDX_W-1:0]   pick_idx,
  input logic               preempt,
  input logic [15:0]        rt_now,
  input logic [N_TASKS-1:0] rdy,
  input logic [N_TASKS-1:0] hrt,
  input logic [N_TASKS-1:0] srt
);

  a_r10_pulse_means_move: assert property (@(posedge clk) disable iff (rst)
    preempt |-> (pick_valid && $past(pick_valid) && (pick_idx != $past(pick_idx))));

  a_r10_steady_no_pulse: assert property (@(posedge clk) disable iff (rst)
    (pick_valid && $past(pick_valid) && (pick_idx == $past(pick_idx))) |-> !preempt);

  a_r8_pick_is_ready: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> rdy[pick_idx]);

  a_r8_idle_when_none: assert property (@(posedge clk) disable iff (rst)
    !pick_valid |-> (rdy == '0));

  a_r2_hard_wins: assert property (@(posedge clk) disable iff (rst)
    (|(rdy & hrt)) |-> (pick_valid && hrt[pick_idx]));

  a_r3_soft_over_plain: assert property (@(posedge clk) disable iff (rst)
    (!(|(rdy & hrt)) && (|(rdy & srt))) |-> (pick_valid && srt[pick_idx]));

  a_r13_tick_step: assert property (@(posedge clk) disable iff (rst)
    16'(rt_now - $past(rt_now)) <= 16'd1);

endmodule

bind mc_task_sched mc_task_sched_chk #(
  .N_TASKS (N_TASKS),
  .IDX_W   (IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pick_valid (pick_valid),
  .pick_idx   (pick_idx),
  .preempt    (preempt),
  .rt_now     (rt_now),
  .rdy        (rdy_vec),
  .hrt        (hrt_vec),
  .srt        (srt_vec)
);

// File: tb/tb_mc_task_sched.sv
module tb_mc_task_sched;

  localparam int OPL = 0, OPR = 1, OPD = 2, OPX = 3;
  localparam int NRT = 0, SRT = 1, HRT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_op = '0;
  logic [2:0]  wr_slot = '0;
  logic [1:0]  wr_cls = '0;
  logic        wr_periodic = 1'b0;
  logic [15:0] wr_period = '0;
  logic [15:0] wr_time = '0;
  logic        pick_valid;
  logic [2:0]  pick_idx;
  logic        preempt;
  logic [15:0] rt_now;

  always #2 clk = ~clk;

  mc_task_sched dut (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_op(wr_op), .wr_slot(wr_slot),
    .wr_cls(wr_cls), .wr_periodic(wr_periodic), .wr_period(wr_period), .wr_time(wr_time),
    .pick_valid(pick_valid), .pick_idx(pick_idx), .preempt(preempt), .rt_now(rt_now)
  );

  typedef struct packed {
    logic       v;
    logic [2:0] idx;
    logic       p;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  // monitor: pop one expectation per falling edge and compare
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (pick_valid !== e.v || (e.v && pick_idx !== e.idx) || preempt !== e.p || wr_ready !== 1'b1) begin
        n_err++;
        $display("FAIL %s: actual valid=%0b idx=%0d preempt=%0b ready=%0b expected valid=%0b idx=%0d preempt=%0b ready=1",
                 t, pick_valid, pick_idx, preempt, wr_ready, e.v, e.idx, e.p);
      end
    end
  end

  task automatic direct(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cmd(input int op, input int slot, input int cls, input bit per_en,
                     input int period, input int tm);
    wr_valid    = 1'b1;
    wr_op       = op[1:0];
    wr_slot     = slot[2:0];
    wr_cls      = cls[1:0];
    wr_periodic = per_en;
    wr_period   = period[15:0];
    wr_time     = tm[15:0];
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic chk(input bit v, input int idx, input bit p, input string tag);
    exp_t e;
    e.v   = v;
    e.idx = idx[2:0];
    e.p   = p;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_now(input int t);
    while (rt_now != t[15:0]) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int t0;
    int r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    direct("R1 pick_valid", pick_valid, 0);
    direct("R1 preempt", preempt, 0);
    direct("R1 wr_ready", wr_ready, 1);
    direct("R1 rt_now", rt_now, 0);

    // R9 unloaded release ignored, load leaves not ready
    cmd(OPR, 4, 0, 0, 0, 100);        chk(0, 0, 0, "R9 release of unloaded slot");
    cmd(OPL, 5, NRT, 0, 0, 0);        chk(0, 0, 0, "R9 load not ready");
    cmd(OPR, 5, 0, 0, 0, 0);          chk(1, 5, 0, "R9 release plain slot5");
    // R11 back-to-back commands; R6 first arrival wins over lower index
    cmd(OPL, 2, NRT, 0, 0, 0);
    cmd(OPR, 2, 0, 0, 0, 0);          chk(1, 5, 0, "R6 R11 earlier plain arrival");
    // R3 soft beats plain, R10 pulse
    cmd(OPL, 6, SRT, 0, 50, 0);
    cmd(OPR, 6, 0, 0, 0, 0);          chk(1, 6, 1, "R3 R10 soft over plain");
    tick();                           chk(1, 6, 0, "R10 single pulse");
    // R5 rate monotonic, R7 tie
    cmd(OPL, 3, SRT, 0, 30, 0);
    cmd(OPR, 3, 0, 0, 0, 0);          chk(1, 3, 1, "R5 shorter period");
    cmd(OPL, 1, SRT, 0, 30, 0);
    cmd(OPR, 1, 0, 0, 0, 0);          chk(1, 1, 1, "R7 equal period lower index");
    // R2 hard wins, R4 EDF with wrap
    cmd(OPL, 7, HRT, 0, 0, 0);
    cmd(OPR, 7, 0, 0, 0, 16'h0010);   chk(1, 7, 1, "R2 hard over soft");
    cmd(OPL, 0, HRT, 0, 0, 0);
    cmd(OPR, 0, 0, 0, 0, 16'hFFF0);   chk(1, 0, 1, "R4 0xFFF0 before 0x0010");
    cmd(OPR, 0, 0, 0, 0, 16'h0020);   chk(1, 7, 1, "R4 later deadline loses");
    // R8 done and remove
    cmd(OPD, 7, 0, 0, 0, 0);          chk(1, 0, 1, "R8 done slot7");
    cmd(OPX, 0, 0, 0, 0, 0);          chk(1, 1, 1, "R8 remove slot0");
    cmd(OPD, 1, 0, 0, 0, 0);          chk(1, 3, 1, "R8 done slot1");
    cmd(OPD, 3, 0, 0, 0, 0);          chk(1, 6, 1, "R5 next soft");
    cmd(OPD, 6, 0, 0, 0, 0);          chk(1, 5, 1, "R6 plain order slot5");
    cmd(OPD, 5, 0, 0, 0, 0);          chk(1, 2, 1, "R6 plain order slot2");
    cmd(OPD, 2, 0, 0, 0, 0);          chk(0, 0, 0, "R8 none ready");
    // R6 reversed arrival
    cmd(OPR, 2, 0, 0, 0, 0);          chk(1, 2, 0, "R6 slot2 alone");
    cmd(OPR, 5, 0, 0, 0, 0);          chk(1, 2, 0, "R6 slot2 arrived first");
    cmd(OPD, 2, 0, 0, 0, 0);          chk(1, 5, 1, "R6 slot5 after");
    cmd(OPD, 5, 0, 0, 0, 0);          chk(0, 0, 0, "R8 idle again");

    // R12 periodic release
    t0 = rt_now;
    cmd(OPL, 4, HRT, 1, 20, t0 + 6);  chk(0, 0, 0, "R12 periodic loaded not ready");
    wait_now(t0 + 5);
    tick();                           chk(0, 0, 0, "R12 not before release time");
    tick();                           chk(1, 4, 0, "R12 released at tick");
    cmd(OPL, 0, HRT, 0, 0, 0);
    cmd(OPR, 0, 0, 0, 0, t0 + 25);    chk(1, 0, 1, "R12 deadline after rel+19");
    cmd(OPR, 0, 0, 0, 0, t0 + 26);    chk(1, 0, 0, "R12 R7 deadline equals rel+20");
    cmd(OPR, 0, 0, 0, 0, t0 + 27);    chk(1, 4, 1, "R12 deadline before rel+21");
    cmd(OPD, 0, 0, 0, 0, 0);          chk(1, 4, 0, "R8 done slot0");
    cmd(OPD, 4, 0, 0, 0, 0);          chk(0, 0, 0, "R8 periodic done");
    wait_now(t0 + 25);
    tick();                           chk(0, 0, 0, "R12 next release not early");
    tick();                           chk(1, 4, 0, "R12 next release after period");

    // R13 tick step
    r = rt_now;
    @(negedge clk);
    direct("R13 tick increment", rt_now, (r + 1) & 16'hFFFF);

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule